// File: doc/BRIEF.md
# AES Forward Column Mixer

This block applies the forward column-mixing step of the AES round to a 128-bit state. The state is viewed as a 4x4 byte matrix, and each of its four columns is multiplied independently by a fixed circulant matrix over GF(2^8) with the reduction polynomial x^8+x^4+x^3+x+1. No multiplier tables are used. Doubling a byte is a one-bit left shift followed by a conditional XOR with 0x1B. Tripling is the doubled value XORed with the original byte. The four products that form each output byte are combined with XOR.

A state presented with `valid_i` high appears mixed on `state_o` one clock later, with `valid_o` high for that cycle. The output register keeps its value while no new state arrives. The block is meant to sit inside an encryption round pipeline between row shifting and round-key addition.

Top module: `mixcol_core`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0.
- R2: `valid_o` at each clock edge equals `valid_i` as sampled at the previous edge.
- R3: One clock after `valid_i` is high, `state_o` holds the mixed input. Output row r of each column is the XOR over input rows j of coef((j-r) mod 4) times in[j], with coef = {2,3,1,1}.
- R4: When `valid_i` is low, `state_o` keeps its previous value at the next edge.
- R5: The state is packed column-major. Column c occupies bits [127-32c -: 32], and row r of that column occupies bits [127-32c-8r -: 8]. A lone byte 0x57 at row 2, column 1 yields column 1 = {0x57,0xF9,0xAE,0x57}.
- R6: Each output column depends only on the input column at the same position. An all-zero input column gives an all-zero output column.
- R7: Doubling a byte whose top bit is set reduces with 0x1B. Input column {0x80,0,0,0} yields {0x1B,0x80,0x80,0x9B}.
- R8: Input column {0xDB,0x13,0x53,0x45} yields {0x8E,0x4D,0xA1,0xBC}.
- R9: A column whose four bytes are equal is mapped to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input state is valid |
| state_i | input | 128 | Input state, column-major |
| valid_o | output | 1 | Output state is valid |
| state_o | output | 128 | Mixed state, column-major |

## Verification
Every result of this block is due exactly one clock edge after its stimulus, because the only register between input and output is the output stage itself.

The bench changes inputs on the falling edge. It then waits for the next falling edge before it reads `state_o` and `valid_o`, so exactly one rising edge lies between stimulus and sample. Hold behaviour is checked the same way: an idle cycle follows a loaded state, and the bench reads the output again after that cycle. Expected columns come from a bit-serial GF(2^8) multiply in the bench, which shares no structure with the shift-and-reduce logic.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ROWS   = 4;
  localparam int unsigned COL_W  = BYTE_W * ROWS;
  localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [COL_W-1:0]  col_t;
endpackage

// File: rtl/gf_xtime.sv
module gf_xtime
  import mixcol_pkg::*;
(
  input  byte_t a_i,
  output byte_t x2_o,
  output byte_t x3_o
);
  byte_t shifted;

  always_comb begin
    shifted = {a_i[BYTE_W-2:0], 1'b0};
    x2_o    = a_i[BYTE_W-1] ? (shifted ^ RED_POLY) : shifted;
    x3_o    = x2_o ^ a_i;
  end
endmodule

// File: rtl/mixcol_column.sv
module mixcol_column
  import mixcol_pkg::*;
(
  input  col_t col_i,
  output col_t col_o
);
  byte_t in_b [ROWS];
  byte_t dbl  [ROWS];
  byte_t trp  [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign in_b[r] = col_i[COL_W-1-BYTE_W*r -: BYTE_W];

    gf_xtime u_xt (
      .a_i  (in_b[r]),
      .x2_o (dbl[r]),
      .x3_o (trp[r])
    );

    // row r: 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3]
    assign col_o[COL_W-1-BYTE_W*r -: BYTE_W] =
        dbl[r] ^ trp[(r+1)%ROWS] ^ in_b[(r+2)%ROWS] ^ in_b[(r+3)%ROWS];
  end
endmodule

// File: rtl/mixcol_core.sv
module mixcol_core
  import mixcol_pkg::*;
#(
  parameter int unsigned NUM_COLS = 4,
  localparam int unsigned STATE_W = NUM_COLS * COL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [STATE_W-1:0] state_i,
  output logic               valid_o,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] mixed;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    mixcol_column u_col (
      .col_i (state_i[STATE_W-1-COL_W*c -: COL_W]),
      .col_o (mixed[STATE_W-1-COL_W*c -: COL_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  // data register has no reset; it loads only on a valid input
  always_ff @(posedge clk_i) begin
    if (valid_i) state_o <= mixed;
  end
endmodule

// File: rtl/mixcol_core_chk.sv
module mixcol_core_chk
  import mixcol_pkg::*;
#(
  parameter int unsigned NUM_COLS = 4,
  localparam int unsigned STATE_W = NUM_COLS * COL_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [STATE_W-1:0] state_i,
  input logic               valid_o,
  input logic [STATE_W-1:0] state_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  function automatic byte_t ref_mul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t x   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc ^= x;
      x = x[BYTE_W-1] ? ((x << 1) ^ RED_POLY) : (x << 1);
    end
    return acc;
  endfunction

  function automatic byte_t ref_c0r0(logic [STATE_W-1:0] s);
    return ref_mul(s[STATE_W-1 -: 8], 8'd2) ^ ref_mul(s[STATE_W-9 -: 8], 8'd3)
         ^ s[STATE_W-17 -: 8] ^ s[STATE_W-25 -: 8];
  endfunction

  assert_reset_valid_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i));

  assert_mix_first_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(valid_i) |-> state_o[STATE_W-1 -: 8] == ref_c0r0($past(state_i)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(valid_i) && $past(armed) |-> $stable(state_o));

  assert_fixed_point_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(valid_i)
    && $past(state_i[STATE_W-1 -: 8]) == $past(state_i[STATE_W-9 -: 8])
    && $past(state_i[STATE_W-1 -: 8]) == $past(state_i[STATE_W-17 -: 8])
    && $past(state_i[STATE_W-1 -: 8]) == $past(state_i[STATE_W-25 -: 8])
    |-> state_o[STATE_W-1 -: COL_W] == $past(state_i[STATE_W-1 -: COL_W]));
endmodule

bind mixcol_core mixcol_core_chk #(.NUM_COLS(NUM_COLS)) u_chk (.*);

// File: tb/tb_mixcol_core.sv
module tb_mixcol_core;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         valid_i = 1'b0;
  logic [127:0] state_i = '0;
  logic         valid_o;
  logic [127:0] state_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  mixcol_core dut (.*);

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [127:0] model(logic [127:0] s);
    logic [7:0] cf [4] = '{8'd2, 8'd3, 8'd1, 8'd1};
    logic [127:0] o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 0;
        for (int j = 0; j < 4; j++)
          acc ^= gmul(s[127-32*c-8*j -: 8], cf[(j-r+4)%4]);
        o[127-32*c-8*r -: 8] = acc;
      end
    return o;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one cycle, sample after the capturing edge
  task automatic apply(logic [127:0] s, logic v);
    @(negedge clk_i);
    state_i = s;
    valid_i = v;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1", {127'd0, valid_o}, 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {127'd0, valid_o}, 128'd0);
  endtask

  task automatic t_known;
    logic [127:0] s = {4{32'hDB135345}};
    apply(s, 1'b1);
    chk("R8", state_o, {4{32'h8E4DA1BC}});
    chk("R2", {127'd0, valid_o}, 128'd1);
  endtask

  task automatic t_reduce;
    apply({32'h80000000, 96'd0}, 1'b1);
    chk("R7", state_o, {32'h1B80809B, 96'd0});
    chk("R6", state_o[95:0], 96'd0);
  endtask

  task automatic t_pack;
    logic [127:0] s = '0;
    s[127-32*1-8*2 -: 8] = 8'h57;
    apply(s, 1'b1);
    chk("R5", state_o, {32'd0, 32'h57F9AE57, 64'd0});
  endtask

  task automatic t_fixed;
    logic [127:0] s = {32'h01010101, 32'hA5A5A5A5, 32'hFFFFFFFF, 32'h00000000};
    apply(s, 1'b1);
    chk("R9", state_o, s);
  endtask

  task automatic t_isolate;
    logic [127:0] a = {32'h11223344, 32'hDB135345, 32'hC0FFEE00, 32'h0BADF00D};
    logic [127:0] b = a;
    b[31:0] = 32'hDEADBEEF;
    apply(a, 1'b1);
    chk("R6", state_o, model(a));
    apply(b, 1'b1);
    chk("R6", state_o[127:32], model(a) >> 32);
  endtask

  task automatic t_hold;
    logic [127:0] s = {32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 32'h4B5A6978};
    apply(s, 1'b1);
    apply(~s, 1'b0);
    chk("R4", state_o, model(s));
    chk("R2", {127'd0, valid_o}, 128'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 24; i++) begin
      logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
      apply(s, 1'b1);
      chk("R3", state_o, model(s));
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_known();
    t_reduce();
    t_pack();
    t_fixed();
    t_isolate();
    t_hold();
    t_random();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule